// File: doc/BRIEF.md
# SLIP Frame Decoder

This block takes a byte stream, one byte per cycle when the input strobe is high, and strips the serial-line framing from it. An escape prefix followed by one of two substitute codes is turned back into the delimiter or escape value it stands for. The delimiter itself ends a packet and is never passed on. The decoded payload leaves as a registered byte stream with a valid strobe, a last flag on the final byte of each packet and an empty flag for packets that carry no bytes. All four special code values are runtime inputs and may change between packets.

Every payload byte is held back by one stage. This lets the byte that sits just before a delimiter carry the last flag. A packet with no payload is reported by a single beat with valid, last and empty all high and the data at zero.

Top module: `slip_unframer`

## Requirements
- R1: After reset the outputs are low, the escape flag is clear and the hold stage is empty, so a first byte equal to codeEscEnd passes as ordinary payload.
- R2: A byte that is not codeEsc or codeEnd, with no escape pending, is payload. It appears on outByte with outLast low in the cycle after the next payload byte is accepted.
- R3: A byte equal to codeEsc with no escape pending sets the escape flag and produces no output beat.
- R4: With an escape pending, a byte equal to codeEscEnd clears the flag and becomes a payload byte whose value is codeEnd.
- R5: With an escape pending, a byte equal to codeEscEsc but not codeEscEnd clears the flag and becomes a payload byte whose value is codeEsc.
- R6: With an escape pending, any other byte, including codeEnd, clears the flag and is dropped without a trace.
- R7: A byte equal to codeEnd with no escape pending and a held byte emits that byte with outLast high and outEmpty low, and leaves the hold stage empty.
- R8: A byte equal to codeEnd with no escape pending and nothing held emits one beat with outValid, outLast and outEmpty high and outByte 0x00.
- R9: While inValid is low, no state changes and outValid is low in the following cycle.
- R10: The codes are sampled every cycle. When a byte matches both codeEsc and codeEnd, the escape test wins.
- R11: Outputs are registered. A beat caused by the input accepted at a clock edge is visible right after that edge. outLast and outEmpty are high only together with outValid, and outEmpty only with outLast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| inValid | input | 1 | input byte strobe |
| inByte | input | 8 | framed input byte |
| codeEnd | input | 8 | delimiter code (default 0xC0) |
| codeEsc | input | 8 | escape prefix code (default 0xDB) |
| codeEscEnd | input | 8 | substitute meaning delimiter (default 0xDC) |
| codeEscEsc | input | 8 | substitute meaning escape (default 0xDD) |
| outValid | output | 1 | output beat strobe |
| outByte | output | 8 | decoded payload byte |
| outLast | output | 1 | beat closes a packet |
| outEmpty | output | 1 | beat is a zero-length packet |

## Verification
Two things can happen in the same cycle. A new payload byte can be loaded into the hold stage while the old one is sent out, and a delimiter can flush the held byte with outLast while the stage is cleared. Back-to-back payload followed at once by a delimiter, and delimiter pairs, cause both. Runs of escaped bytes placed right before a delimiter make the escape decode coincide with the flush. A bench model predicts every output cycle from the requirements, and each cycle is compared beat by beat, including the quiet cycles.

// File: rtl/slip_unframer_pkg.sv
package slip_unframer_pkg;
  typedef enum logic [1:0] {
    PAY_RAW = 2'd0,
    PAY_END = 2'd1,
    PAY_ESC = 2'd2
  } paySel_e;

  typedef struct packed {
    logic    pushPay;
    paySel_e paySel;
    logic    closePkt;
  } slipStrobe_t;

  localparam logic [7:0] DEF_END     = 8'hC0;
  localparam logic [7:0] DEF_ESC     = 8'hDB;
  localparam logic [7:0] DEF_ESC_END = 8'hDC;
  localparam logic [7:0] DEF_ESC_ESC = 8'hDD;
endpackage

// File: rtl/slip_unframer_ctrl.sv
module slip_unframer_ctrl
  import slip_unframer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] inByte,
  input  logic [W-1:0] codeEnd,
  input  logic [W-1:0] codeEsc,
  input  logic [W-1:0] codeEscEnd,
  input  logic [W-1:0] codeEscEsc,
  output slipStrobe_t  strb
);
  logic escPending, escNext;

  always_comb begin
    strb     = '{pushPay: 1'b0, paySel: PAY_RAW, closePkt: 1'b0};
    escNext  = escPending;
    if (inValid) begin
      if (escPending) begin
        escNext = 1'b0;
        if (inByte == codeEscEnd) begin
          strb.pushPay = 1'b1;
          strb.paySel  = PAY_END;
        end else if (inByte == codeEscEsc) begin
          strb.pushPay = 1'b1;
          strb.paySel  = PAY_ESC;
        end
      end else if (inByte == codeEsc) begin
        escNext = 1'b1;
      end else if (inByte == codeEnd) begin
        strb.closePkt = 1'b1;
      end else begin
        strb.pushPay = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) escPending <= 1'b0;
    else       escPending <= escNext;
  end
endmodule

// File: rtl/slip_unframer_dpath.sv
module slip_unframer_dpath
  import slip_unframer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  slipStrobe_t  strb,
  input  logic [W-1:0] inByte,
  input  logic [W-1:0] codeEnd,
  input  logic [W-1:0] codeEsc,
  output logic         outValid,
  output logic [W-1:0] outByte,
  output logic         outLast,
  output logic         outEmpty
);
  logic         holdValid;
  logic [W-1:0] holdByte;
  logic [W-1:0] payByte;

  always_comb begin
    unique case (strb.paySel)
      PAY_END: payByte = codeEnd;
      PAY_ESC: payByte = codeEsc;
      default: payByte = inByte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdByte  <= '0;
      outValid  <= 1'b0;
      outByte   <= '0;
      outLast   <= 1'b0;
      outEmpty  <= 1'b0;
    end else begin
      outValid <= 1'b0;
      outByte  <= '0;
      outLast  <= 1'b0;
      outEmpty <= 1'b0;
      if (strb.pushPay) begin
        if (holdValid) begin
          outValid <= 1'b1;
          outByte  <= holdByte;
        end
        holdByte  <= payByte;
        holdValid <= 1'b1;
      end else if (strb.closePkt) begin
        outValid  <= 1'b1;
        outLast   <= 1'b1;
        outEmpty  <= !holdValid;
        outByte   <= holdValid ? holdByte : '0;
        holdValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slip_unframer.sv
module slip_unframer
  import slip_unframer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] inByte,
  input  logic [W-1:0] codeEnd,
  input  logic [W-1:0] codeEsc,
  input  logic [W-1:0] codeEscEnd,
  input  logic [W-1:0] codeEscEsc,
  output logic         outValid,
  output logic [W-1:0] outByte,
  output logic         outLast,
  output logic         outEmpty
);
  slipStrobe_t strb;

  slip_unframer_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .codeEnd(codeEnd), .codeEsc(codeEsc), .codeEscEnd(codeEscEnd),
    .codeEscEsc(codeEscEsc), .strb(strb)
  );

  slip_unframer_dpath #(.W(W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .inByte(inByte),
    .codeEnd(codeEnd), .codeEsc(codeEsc), .outValid(outValid),
    .outByte(outByte), .outLast(outLast), .outEmpty(outEmpty)
  );
endmodule

// File: rtl/slip_unframer_chk.sv
module slip_unframer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [W-1:0] inByte,
  input logic [W-1:0] codeEnd,
  input logic [W-1:0] codeEsc,
  input logic         outValid,
  input logic [W-1:0] outByte,
  input logic         outLast,
  input logic         outEmpty
);
  a_r9_idle_no_beat: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r11_last_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  a_r11_empty_needs_last: assert property (@(posedge clk) disable iff (!rstN)
    outEmpty |-> (outLast && outValid));

  a_r8_empty_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    outEmpty |-> (outByte == '0));

  a_r7_last_only_on_end: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inByte != codeEnd) |=> !outLast);

  a_r3_esc_silent: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inByte == codeEsc && inByte != codeEnd) |=> !outLast);
endmodule

bind slip_unframer slip_unframer_chk #(.W(W)) u_chk (.*);

// File: tb/sim_slip_unframer.sv
module sim_slip_unframer;
  import slip_unframer_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [7:0] inByte, codeEnd, codeEsc, codeEscEnd, codeEscEsc;
  logic       outValid, outLast, outEmpty;
  logic [7:0] outByte;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference state
  bit       mEsc, mHoldV;
  bit [7:0] mHold;

  always #(CLK_PERIOD/2) clk = ~clk;

  slip_unframer u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .codeEnd(codeEnd), .codeEsc(codeEsc), .codeEscEnd(codeEscEnd),
    .codeEscEsc(codeEscEsc), .outValid(outValid), .outByte(outByte),
    .outLast(outLast), .outEmpty(outEmpty)
  );

  task automatic compare(string tag, bit eV, bit [7:0] eB, bit eL, bit eE);
    nChecks++;
    if (outValid !== eV || outByte !== eB || outLast !== eL || outEmpty !== eE) begin
      nFails++;
      $display("FAIL %s: got v=%0b b=%02h l=%0b e=%0b, expected v=%0b b=%02h l=%0b e=%0b",
               tag, outValid, outByte, outLast, outEmpty, eV, eB, eL, eE);
    end
  endtask

  // Drive one cycle (called at a negedge), predict, check at the next negedge.
  task automatic step(string tag, bit v, bit [7:0] b);
    bit eV = 0, eL = 0, eE = 0;
    bit [7:0] eB = 8'h00;
    bit push = 0;
    bit [7:0] pay = 8'h00;
    inValid = v;
    inByte  = b;
    if (v) begin
      if (mEsc) begin
        mEsc = 0;
        if (b == codeEscEnd)      begin push = 1; pay = codeEnd; end
        else if (b == codeEscEsc) begin push = 1; pay = codeEsc; end
      end else if (b == codeEsc) begin
        mEsc = 1;
      end else if (b == codeEnd) begin
        eV = 1; eL = 1;
        if (mHoldV) eB = mHold; else eE = 1;
        mHoldV = 0;
      end else begin
        push = 1; pay = b;
      end
      if (push) begin
        if (mHoldV) begin eV = 1; eB = mHold; end
        mHold = pay; mHoldV = 1;
      end
    end
    @(negedge clk);
    compare(tag, eV, eB, eL, eE);
  endtask

  task automatic setCodes(bit [7:0] e, bit [7:0] s, bit [7:0] se, bit [7:0] ss);
    codeEnd = e; codeEsc = s; codeEscEnd = se; codeEscEsc = ss;
  endtask

  initial begin
    void'($urandom(32'h51A7_0C0D));
    setCodes(DEF_END, DEF_ESC, DEF_ESC_END, DEF_ESC_ESC);
    rstN = 1'b0; inValid = 1'b0; inByte = 8'h00;
    mEsc = 0; mHoldV = 0; mHold = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset outputs", 0, 8'h00, 0, 0);
    rstN = 1'b1;

    // R1: no escape pending after reset, 0xDC is plain payload
    step("R1 first byte", 1, 8'hDC);
    step("R1 close", 1, 8'hC0);
    // R8: empty packet, and two in a row
    step("R8 empty", 1, 8'hC0);
    step("R8 empty again", 1, 8'hC0);
    // R2 / R7 back-to-back payload then END
    step("R2 a", 1, 8'h11);
    step("R2 b", 1, 8'h22);
    step("R9 gap", 0, 8'hC0);
    step("R2 c", 1, 8'h33);
    step("R7 flush", 1, 8'hC0);
    // R3/R4/R5/R6 escape cases
    step("R3 esc", 1, 8'hDB);
    step("R4 esc_end", 1, 8'hDC);
    step("R3 esc", 1, 8'hDB);
    step("R9 idle while pending", 0, 8'h00);
    step("R5 esc_esc", 1, 8'hDD);
    step("R3 esc", 1, 8'hDB);
    step("R6 bad after esc", 1, 8'h55);
    step("R3 esc", 1, 8'hDB);
    step("R6 end after esc", 1, 8'hC0);
    step("R7 close with escaped", 1, 8'hC0);
    step("R3 esc", 1, 8'hDB);
    step("R4 esc_end at tail", 1, 8'hDC);
    step("R7 close", 1, 8'hC0);

    // R10: ESC and END equal -> escape wins
    setCodes(8'h7E, 8'h7E, 8'h5E, 8'h5D);
    step("R10 shared code esc", 1, 8'h7E);
    step("R10 shared code escaped", 1, 8'h5E);
    step("R10 shared esc again", 1, 8'h7E);
    step("R10 shared drop", 1, 8'h7E);

    // R10: new codes, random traffic
    setCodes(8'h0A, 8'h1B, 8'h2C, 8'h3D);
    step("R10 flush", 1, 8'h0A);
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit [7:0] b;
      if (i == 1500) setCodes(DEF_END, DEF_ESC, DEF_ESC_END, DEF_ESC_ESC);
      r = $urandom_range(0, 9);
      case (r)
        0, 1: b = codeEnd;
        2:    b = codeEsc;
        3:    b = codeEscEnd;
        4:    b = codeEscEsc;
        default: b = 8'($urandom);
      endcase
      step("R2/R11 random", ($urandom_range(0, 4) != 0), b);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule